// File: doc/BRIEF.md
# Inter-core interrupt generation unit

This block raises interprocessor interrupts among a cluster of `NCORES` cores. Every core has its own command port. Each cycle, a core can present one command made of a valid strobe, a 2-bit opcode and a core-number argument. The index of the port identifies the issuing core. With these commands a core can raise an interrupt on another core, ask whether a given core already has an interrupt waiting, read the set of cores that are interrupting it, and acknowledge one of those cores.

The block keeps the pending state as a matrix with one row per target core and one bit per sender core. The interrupt line of a target is the OR of its row. Because of this, several senders that hit the same target collapse into a single asserted line, while each sender remains visible in the row. A target clears the senders one at a time, and its line drops only when the whole row is empty. The two query commands answer through a per-core readback register one cycle after the command.

Top module: `ipi_unit`

## Requirements
- R1: A RAISE command (opcode 0) from core s with argument t, where t differs from s, sets pending bit (target t, sender s). `irq[t]` is high from the cycle after the command.
- R2: A RAISE command whose argument equals the issuing core is ignored: no pending bit and no `irq` changes.
- R3: A PEEK command (opcode 1) with argument t sets `rd_valid` of the issuer one cycle later. Bit 0 of that issuer's `rd_data` slice is 1 exactly when target t had any pending sender, and all other bits of the slice are 0.
- R4: A WHO command (opcode 2) returns, one cycle later, the issuer's pending row in its `rd_data` slice: bit s is set when sender s is pending toward the issuer.
- R5: Raises from several cores to one target in the same cycle give one asserted `irq` line for that target, and the target's WHO result shows every one of those senders.
- R6: A CLEAR command (opcode 3) from core t with argument s clears only pending bit (t, s). Other bits in row t and other rows are untouched.
- R7: `irq[t]` stays high until every pending bit in row t has been cleared, and goes low in the cycle after the last clear.
- R8: When a RAISE and a CLEAR address the same pending bit in the same cycle, the bit ends up set.
- R9: After reset all pending bits, `irq`, `rd_valid` and `rd_data` are 0.
- R10: RAISE and CLEAR produce no readback: `rd_valid` and `rd_data` of the issuer are 0 in the next cycle. A query reports the pending state from before any command issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | NCORES | Per-core command strobe |
| cmd_op | input | 2*NCORES | Per-core opcode, slice i = bits [2i+1:2i]; 0 RAISE, 1 PEEK, 2 WHO, 3 CLEAR |
| cmd_arg | input | AW*NCORES | Per-core core-number argument, slice i = bits [AW*i +: AW] |
| rd_valid | output | NCORES | Per-core readback valid, one cycle after a PEEK or WHO |
| rd_data | output | NCORES*NCORES | Per-core readback, slice i = bits [NCORES*i +: NCORES] |
| irq | output | NCORES | Per-target interrupt line, high while any sender is pending |

## Verification
The bench sweeps every sender/target pair with a single raise, including the self-addressed ones. This separates a correct row/column placement from a transposed matrix and shows that self-raises are dropped. Simultaneous raises from all other cores to one target, followed by one-at-a-time clears, separate OR-merging from last-writer behaviour and show that the line holds until the final clear. A same-cycle raise and clear on one bit exposes the wrong priority. A sweep of mixed opcode patterns across all ports at once checks that queries see the state from before the edge and that unrelated bits stay untouched.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    typedef enum logic [1:0] {
        OP_RAISE = 2'd0,
        OP_PEEK  = 2'd1,
        OP_WHO   = 2'd2,
        OP_CLEAR = 2'd3
    } ipi_op_e;
endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode #(
    parameter int NCORES = 4,
    parameter int SELF   = 0,
    parameter int AW     = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input  logic              valid,
    input  logic [1:0]        op,
    input  logic [AW-1:0]     arg,
    output logic [NCORES-1:0] raise_tgt,
    output logic [NCORES-1:0] clear_src,
    output logic              peek,
    output logic              who
);
    import ipi_pkg::*;

    logic arg_ok;

    always_comb begin
        arg_ok    = (int'(arg) < NCORES);
        raise_tgt = '0;
        clear_src = '0;
        peek      = 1'b0;
        who       = 1'b0;
        if (valid) begin
            unique case (ipi_op_e'(op))
                OP_RAISE: if (arg_ok && int'(arg) != SELF) raise_tgt[arg] = 1'b1;
                OP_PEEK:  peek = arg_ok;
                OP_WHO:   who  = 1'b1;
                OP_CLEAR: if (arg_ok) clear_src[arg] = 1'b1;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/ipi_pend_matrix.sv
module ipi_pend_matrix #(
    parameter int NCORES = 4,
    localparam int NB    = NCORES * NCORES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] raise_flat,  // index issuer*N + target
    input  logic [NB-1:0] clear_flat,  // index issuer(target)*N + sender
    output logic [NB-1:0] pend,        // index target*N + sender
    output logic [NCORES-1:0] irq
);
    typedef struct packed {
        logic [NB-1:0] pend;
    } mat_t;

    mat_t st_d, st_q;
    logic [NB-1:0] set_m;
    logic [NB-1:0] clr_m;

    always_comb begin
        for (int t = 0; t < NCORES; t++) begin
            for (int s = 0; s < NCORES; s++) begin
                set_m[t*NCORES+s] = raise_flat[s*NCORES+t];
                clr_m[t*NCORES+s] = clear_flat[t*NCORES+s];
            end
        end
        st_d.pend = (st_q.pend & ~clr_m) | set_m;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;

    for (genvar t = 0; t < NCORES; t++) begin : g_row
        assign irq[t] = |st_q.pend[t*NCORES +: NCORES];

        assert_no_self_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !st_q.pend[t*NCORES+t]);

        assert_line_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[t] && clr_m[t*NCORES +: NCORES] == '0) |=> irq[t]);

        for (genvar s = 0; s < NCORES; s++) begin : g_col
            assert_raise_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
                set_m[t*NCORES+s] |=> st_q.pend[t*NCORES+s]);

            assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_m[t*NCORES+s] && !set_m[t*NCORES+s]) |=> !st_q.pend[t*NCORES+s]);
        end
    end
endmodule

// File: rtl/ipi_unit.sv
module ipi_unit #(
    parameter int NCORES = 4,
    localparam int AW    = (NCORES > 1) ? $clog2(NCORES) : 1,
    localparam int NB    = NCORES * NCORES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCORES-1:0]    cmd_valid,
    input  logic [2*NCORES-1:0]  cmd_op,
    input  logic [AW*NCORES-1:0] cmd_arg,
    output logic [NCORES-1:0]    rd_valid,
    output logic [NB-1:0]        rd_data,
    output logic [NCORES-1:0]    irq
);
    import ipi_pkg::*;

    typedef struct packed {
        logic [NCORES-1:0] vld;
        logic [NB-1:0]     dat;
    } rb_t;

    rb_t rb_d, rb_q;

    logic [NB-1:0]     raise_flat;
    logic [NB-1:0]     clear_flat;
    logic [NCORES-1:0] peek_v;
    logic [NCORES-1:0] who_v;
    logic [NB-1:0]     pend;

    for (genvar i = 0; i < NCORES; i++) begin : g_port
        ipi_cmd_decode #(.NCORES(NCORES), .SELF(i), .AW(AW)) u_dec (
            .valid     (cmd_valid[i]),
            .op        (cmd_op[2*i +: 2]),
            .arg       (cmd_arg[AW*i +: AW]),
            .raise_tgt (raise_flat[i*NCORES +: NCORES]),
            .clear_src (clear_flat[i*NCORES +: NCORES]),
            .peek      (peek_v[i]),
            .who       (who_v[i])
        );
    end

    ipi_pend_matrix #(.NCORES(NCORES)) u_mat (
        .clk        (clk),
        .rst_n      (rst_n),
        .raise_flat (raise_flat),
        .clear_flat (clear_flat),
        .pend       (pend),
        .irq        (irq)
    );

    always_comb begin
        rb_d = '0;
        for (int i = 0; i < NCORES; i++) begin
            if (peek_v[i]) begin
                rb_d.vld[i] = 1'b1;
                for (int t = 0; t < NCORES; t++) begin
                    if (int'(cmd_arg[AW*i +: AW]) == t)
                        rb_d.dat[i*NCORES] = |pend[t*NCORES +: NCORES];
                end
            end else if (who_v[i]) begin
                rb_d.vld[i] = 1'b1;
                rb_d.dat[i*NCORES +: NCORES] = pend[i*NCORES +: NCORES];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rb_q <= '0;
        else        rb_q <= rb_d;
    end

    assign rd_valid = rb_q.vld;
    assign rd_data  = rb_q.dat;

    for (genvar i = 0; i < NCORES; i++) begin : g_chk
        assert_peek_reply_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid[i] && cmd_op[2*i +: 2] == OP_PEEK && int'(cmd_arg[AW*i +: AW]) < NCORES)
            |=> (rd_valid[i] && rd_data[i*NCORES+1 +: NCORES-1] == '0));

        assert_who_reply_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid[i] && cmd_op[2*i +: 2] == OP_WHO) |=> rd_valid[i]);

        assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !(cmd_valid[i] && (cmd_op[2*i +: 2] == OP_PEEK || cmd_op[2*i +: 2] == OP_WHO))
            |=> (!rd_valid[i] && rd_data[i*NCORES +: NCORES] == '0));
    end
endmodule

// File: tb/ipi_unit_test.sv
module ipi_unit_test;
    localparam int N  = 4;
    localparam int AW = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   cmd_valid = '0;
    logic [2*N-1:0] cmd_op = '0;
    logic [AW*N-1:0] cmd_arg = '0;
    logic [N-1:0]   rd_valid;
    logic [N*N-1:0] rd_data;
    logic [N-1:0]   irq;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [N*N-1:0] mdl = '0;  // index target*N + sender

    always #4 clk = ~clk;

    ipi_unit #(.NCORES(N)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(input int core, input int op, input int arg);
        cmd_valid[core] = 1'b1;
        cmd_op[2*core +: 2] = op[1:0];
        cmd_arg[AW*core +: AW] = arg[AW-1:0];
    endtask

    function automatic logic [N-1:0] exp_irq(input logic [N*N-1:0] m);
        logic [N-1:0] r;
        for (int t = 0; t < N; t++) r[t] = |m[t*N +: N];
        return r;
    endfunction

    // Called at a negedge after put(); checks all outputs one cycle later.
    task automatic step(input string tag);
        logic [N*N-1:0] setv, clrv, erd;
        logic [N-1:0] erv;
        setv = '0; clrv = '0; erd = '0; erv = '0;
        for (int i = 0; i < N; i++) begin
            if (cmd_valid[i]) begin
                int a;
                a = int'(cmd_arg[AW*i +: AW]);
                case (int'(cmd_op[2*i +: 2]))
                    0: if (a != i) setv[a*N+i] = 1'b1;
                    1: begin erv[i] = 1'b1; erd[i*N] = ((mdl >> (a*N)) & 16'hF) != 0; end
                    2: begin erv[i] = 1'b1; erd[i*N +: N] = mdl[i*N +: N]; end
                    default: clrv[i*N+a] = 1'b1;
                endcase
            end
        end
        mdl = (mdl & ~clrv) | setv;
        @(negedge clk);
        cmd_valid = '0;
        check({tag, " rd_valid"}, 32'(rd_valid), 32'(erv));
        check({tag, " rd_data"}, 32'(rd_data), 32'(erd));
        check({tag, " irq"}, 32'(irq), 32'(exp_irq(mdl)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 irq", 32'(irq), 0);
        check("R9 rd_valid", 32'(rd_valid), 0);
        check("R9 rd_data", 32'(rd_data), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2/R3/R4/R6 sweep over every sender/target pair
        for (int s = 0; s < N; s++) begin
            for (int t = 0; t < N; t++) begin
                put(s, 0, t);           step((s == t) ? "R2 self raise" : "R1 raise");
                put((s + 1) % N, 1, t); step("R3 peek");
                put(t, 2, 0);           step("R4 who");
                put(t, 3, s);           step("R6 clear");
            end
        end

        // R5 merge, R7 hold until last clear
        put(1, 0, 0); put(2, 0, 0); put(3, 0, 0); step("R5 merge raise");
        put(0, 2, 0); step("R5 who");
        check("R5 who bitmap", 32'(rd_data[3:0]), 32'hE);
        put(0, 3, 2); step("R7 clear 2");
        check("R7 still high", 32'(irq[0]), 1);
        put(0, 3, 1); step("R7 clear 1");
        check("R7 still high", 32'(irq[0]), 1);
        put(0, 3, 3); step("R7 clear 3");
        check("R7 dropped", 32'(irq[0]), 0);

        // R8 raise beats simultaneous clear
        put(1, 0, 2); step("R8 setup");
        put(1, 0, 2); put(2, 3, 1); step("R8 collide");
        check("R8 bit kept", 32'(irq[2]), 1);
        put(2, 3, 1); step("R8 cleanup");

        // R10 query sees state before same-cycle raise
        put(3, 0, 1); put(0, 1, 1); put(1, 2, 0); step("R10 pre-edge view");
        check("R10 peek old", 32'(rd_data[0]), 0);
        put(1, 3, 3); step("R10 clear no reply");

        // mixed patterns on all ports at once
        for (int p = 0; p < 256; p++) begin
            for (int c = 0; c < N; c++)
                put(c, (p >> (2*c)) & 3, (p * 7 + c * 3 + (p >> 3)) % N);
            step("R6 R10 mixed");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule